// File: doc/BRIEF.md
# Cross-Lane Operand Permutation Network

This block sits in front of the ALU of a 64-lane vector unit and provides one source operand taken from other lanes. Each issued operation supplies a 64-lane operand vector, a per-lane activity vector and a permutation code. The block returns the rearranged vector and a per-lane write enable one clock later.

The permutations are fixed and never leave aligned clusters of 4, 8, 16, 32 or 64 lanes. The lanes are grouped into four rows of 16 lanes. Each row is split into four banks of 4 lanes.

The write enables are formed from three inputs:
- a 4-bit row mask;
- a 4-bit bank mask;
- the validity of the lane each output lane reads from.

A bound-control flag chooses what happens to a lane whose source is out of range or inactive. With the flag set, the lane is written with zero. With the flag clear, the lane is not written at all.

Top module: `lane_perm_net`

## Requirements
- R1: Mode code 0 (quad) gives output lane 4q+k the value of lane 4q+s, where s is quad_sel[2k+1:2k].
- R2: Mode code 1 (half-row mirror) gives output lane 8g+k the value of lane 8g+7-k.
- R3: Mode code 2 gives row lane p the value of row lane p+n, and mode code 3 gives it the value of row lane p-n, where n is shift_amt. A source that falls outside the 16-lane row is invalid, and n = 0 selects the lane itself.
- R4: Mode code 4 (row rotate right) gives row lane p the value of row lane (p-n) mod 16. Mode code 5 (row mirror) gives row lane p the value of row lane 15-p.
- R5: Mode code 6 gives every lane of row r, for r ≥ 1, the value of lane 16r-1. Row 0 has no valid source.
- R6: Mode code 7 gives lanes 32..63 the value of lane 31. Lanes 0..31 have no valid source.
- R7: Across all 64 lanes, lane i is sourced as follows:
  - mode code 8: lane i+1, and lane 63 is invalid;
  - mode code 9: lane i-1, and lane 0 is invalid;
  - mode code 10: lane (i+1) mod 64;
  - mode code 11: lane (i-1) mod 64.
- R8: A lane may be written only when row_mask bit r is set for its row r (lanes 16r..16r+15) and bank_mask bit b is set for its bank b (lanes 16r+4b..16r+4b+3). For example, row_mask 0xa enables only rows 1 and 3.
- R9: With bound_ctl set, every lane enabled by R8 is written. A lane whose source is invalid, or whose source lane is inactive in src_act, receives zero.
- R10: With bound_ctl clear, a lane whose source is invalid or inactive has its write enable low and its data zero.
- R11: Results appear one clock after issue, with res_valid high. In a cycle after no issue, res_valid and all of res_we are low, and the same holds out of reset.
- R12: Mode codes 12..15 have no valid source for any lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue | input | 1 | Operation issued this cycle |
| src_data | input | 64*DATA_W | Operand vector, lane i at bits i*DATA_W upward |
| src_act | input | 64 | Per-lane activity of the source lanes |
| perm_mode | input | 4 | Permutation code |
| shift_amt | input | 4 | Row shift or rotate distance |
| quad_sel | input | 8 | Per-lane source index within a quad, 2 bits each |
| row_mask | input | 4 | Write enable per 16-lane row |
| bank_mask | input | 4 | Write enable per 4-lane bank within each row |
| bound_ctl | input | 1 | Write zero for lanes whose source is bad |
| res_valid | output | 1 | Result valid |
| res_data | output | 64*DATA_W | Permuted operand vector |
| res_we | output | 64 | Per-lane write enable |

## Verification
The bench builds the block with DATA_W = 16. This width is enough to tag every lane's value with its own lane number and a per-operation salt, so any misrouted lane shows up as a wrong value. The bench sweeps every mode code, including the unused ones. For each mode it tries shift distances 0, 1, 5 and 15 and several quad selectors. It repeats these with four mask combinations, both bound-control settings and two activity patterns. That covers the row edges, the wrap-around, the invalid-source cases and the masked lanes in every mode.

// File: rtl/lperm_pkg.sv
package lperm_pkg;
  localparam int LANES      = 64;
  localparam int ROW_LANES  = 16;
  localparam int ROWS       = LANES / ROW_LANES;
  localparam int BANK_LANES = 4;
  localparam int BANKS      = ROW_LANES / BANK_LANES;
  localparam int LANE_IW    = $clog2(LANES);

  typedef enum logic [3:0] {
    PM_QUAD      = 4'd0,
    PM_HALF_MIR  = 4'd1,
    PM_ROW_SHL   = 4'd2,
    PM_ROW_SHR   = 4'd3,
    PM_ROW_ROR   = 4'd4,
    PM_ROW_MIR   = 4'd5,
    PM_BCAST_ROW = 4'd6,
    PM_BCAST_HLF = 4'd7,
    PM_WAVE_SHL  = 4'd8,
    PM_WAVE_SHR  = 4'd9,
    PM_WAVE_ROL  = 4'd10,
    PM_WAVE_ROR  = 4'd11
  } perm_mode_e;

  typedef struct packed {
    logic               ok;
    logic [LANE_IW-1:0] idx;
  } src_sel_t;

  // Source lane for one output lane; ok=0 means no valid source.
  function automatic src_sel_t pick_source(input int lane, input perm_mode_e mode,
                                           input logic [3:0] amt, input logic [7:0] qsel);
    src_sel_t r;
    int row, pos, n, t;
    row  = lane / ROW_LANES;
    pos  = lane % ROW_LANES;
    n    = int'(amt);
    t    = 0;
    r.ok = 1'b0;
    case (mode)
      PM_QUAD: begin
        r.ok = 1'b1;
        t = (lane / 4) * 4 + int'(qsel[2*(lane%4) +: 2]);
      end
      PM_HALF_MIR: begin
        r.ok = 1'b1;
        t = (lane / 8) * 8 + 7 - (lane % 8);
      end
      PM_ROW_SHL: begin
        r.ok = (pos + n) < ROW_LANES;
        t = row * ROW_LANES + ((pos + n) % ROW_LANES);
      end
      PM_ROW_SHR: begin
        r.ok = pos >= n;
        t = row * ROW_LANES + ((pos + ROW_LANES - n) % ROW_LANES);
      end
      PM_ROW_ROR: begin
        r.ok = 1'b1;
        t = row * ROW_LANES + ((pos + ROW_LANES - n) % ROW_LANES);
      end
      PM_ROW_MIR: begin
        r.ok = 1'b1;
        t = row * ROW_LANES + ROW_LANES - 1 - pos;
      end
      PM_BCAST_ROW: begin
        r.ok = row > 0;
        t = (row > 0) ? row * ROW_LANES - 1 : 0;
      end
      PM_BCAST_HLF: begin
        r.ok = lane >= LANES / 2;
        t = LANES / 2 - 1;
      end
      PM_WAVE_SHL: begin
        r.ok = lane < LANES - 1;
        t = (lane + 1) % LANES;
      end
      PM_WAVE_SHR: begin
        r.ok = lane > 0;
        t = (lane + LANES - 1) % LANES;
      end
      PM_WAVE_ROL: begin
        r.ok = 1'b1;
        t = (lane + 1) % LANES;
      end
      PM_WAVE_ROR: begin
        r.ok = 1'b1;
        t = (lane + LANES - 1) % LANES;
      end
      default: begin
        r.ok = 1'b0;
        t = 0;
      end
    endcase
    r.idx = LANE_IW'(t);
    return r;
  endfunction

  // Row and bank masking for one lane position.
  function automatic logic lane_enable(input int lane, input logic [ROWS-1:0] rmask,
                                       input logic [BANKS-1:0] bmask);
    return rmask[lane / ROW_LANES] & bmask[(lane % ROW_LANES) / BANK_LANES];
  endfunction
endpackage

// File: rtl/lperm_route.sv
module lperm_route
  import lperm_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [LANES*DATA_W-1:0] src_data,
  input  logic [LANES-1:0]        src_act,
  input  logic [3:0]              mode,
  input  logic [3:0]              amt,
  input  logic [7:0]              qsel,
  output logic [LANES*DATA_W-1:0] routed,
  output logic [LANES-1:0]        src_good
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    src_sel_t sel;
    always_comb sel = pick_source(i, perm_mode_e'(mode), amt, qsel);
    assign src_good[i] = sel.ok & src_act[sel.idx];
    assign routed[i*DATA_W +: DATA_W] =
      src_good[i] ? src_data[int'(sel.idx)*DATA_W +: DATA_W] : '0;
  end
endmodule

// File: rtl/lperm_mask.sv
module lperm_mask
  import lperm_pkg::*;
(
  input  logic [ROWS-1:0]  row_mask,
  input  logic [BANKS-1:0] bank_mask,
  output logic [LANES-1:0] lane_en
);
  for (genvar i = 0; i < LANES; i++) begin : g_en
    assign lane_en[i] = lane_enable(i, row_mask, bank_mask);
  end
endmodule

// File: rtl/lperm_stage.sv
module lperm_stage
  import lperm_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    issue,
  input  logic                    bound_ctl,
  input  logic [LANES*DATA_W-1:0] routed,
  input  logic [LANES-1:0]        src_good,
  input  logic [LANES-1:0]        lane_en,
  output logic                    res_valid,
  output logic [LANES*DATA_W-1:0] res_data,
  output logic [LANES-1:0]        res_we
);
  logic [LANES-1:0] we_next;
  assign we_next = lane_en & (src_good | {LANES{bound_ctl}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_we    <= '0;
      res_data  <= '0;
    end else begin
      res_valid <= issue;
      res_we    <= issue ? we_next : '0;
      if (issue) res_data <= routed;
    end
  end
endmodule

// File: rtl/lane_perm_net.sv
module lane_perm_net
  import lperm_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    issue,
  input  logic [LANES*DATA_W-1:0] src_data,
  input  logic [LANES-1:0]        src_act,
  input  logic [3:0]              perm_mode,
  input  logic [3:0]              shift_amt,
  input  logic [7:0]              quad_sel,
  input  logic [ROWS-1:0]         row_mask,
  input  logic [BANKS-1:0]        bank_mask,
  input  logic                    bound_ctl,
  output logic                    res_valid,
  output logic [LANES*DATA_W-1:0] res_data,
  output logic [LANES-1:0]        res_we
);
  logic [LANES*DATA_W-1:0] routed;
  logic [LANES-1:0]        src_good;
  logic [LANES-1:0]        lane_en;

  lperm_route #(.DATA_W(DATA_W)) route_i (
    .src_data(src_data), .src_act(src_act), .mode(perm_mode), .amt(shift_amt),
    .qsel(quad_sel), .routed(routed), .src_good(src_good)
  );

  lperm_mask mask_i (
    .row_mask(row_mask), .bank_mask(bank_mask), .lane_en(lane_en)
  );

  lperm_stage #(.DATA_W(DATA_W)) stage_i (
    .clk(clk), .rst_n(rst_n), .issue(issue), .bound_ctl(bound_ctl),
    .routed(routed), .src_good(src_good), .lane_en(lane_en),
    .res_valid(res_valid), .res_data(res_data), .res_we(res_we)
  );
endmodule

// File: rtl/lane_perm_net_chk.sv
module lane_perm_net_chk
  import lperm_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             issue,
  input logic             bound_ctl,
  input logic [LANES-1:0] lane_en,
  input logic [LANES-1:0] src_good,
  input logic             res_valid,
  input logic [LANES-1:0] res_we
);
  a_r11_valid_follows_issue: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> res_valid);

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |=> (!res_valid && res_we == '0));

  a_r8_we_within_mask: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> ((res_we & ~$past(lane_en)) == '0));

  a_r9_bound_writes_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && bound_ctl) |=> (res_we == $past(lane_en)));

  a_r10_bad_src_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !bound_ctl) |=> ((res_we & ~$past(src_good)) == '0));
endmodule

bind lane_perm_net lane_perm_net_chk chk_i (
  .clk(clk), .rst_n(rst_n), .issue(issue), .bound_ctl(bound_ctl),
  .lane_en(lane_en), .src_good(src_good), .res_valid(res_valid), .res_we(res_we)
);

// File: tb/lane_perm_net_tb_top.sv
module lane_perm_net_tb_top;
  localparam int DW = 16;
  localparam int NL = 64;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            issue = 1'b0;
  logic [NL*DW-1:0] src_data = '0;
  logic [NL-1:0]   src_act = '0;
  logic [3:0]      perm_mode = '0;
  logic [3:0]      shift_amt = '0;
  logic [7:0]      quad_sel = '0;
  logic [3:0]      row_mask = '0;
  logic [3:0]      bank_mask = '0;
  logic            bound_ctl = 1'b0;
  logic            res_valid;
  logic [NL*DW-1:0] res_data;
  logic [NL-1:0]   res_we;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  lane_perm_net #(.DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .issue(issue), .src_data(src_data), .src_act(src_act),
    .perm_mode(perm_mode), .shift_amt(shift_amt), .quad_sel(quad_sel),
    .row_mask(row_mask), .bank_mask(bank_mask), .bound_ctl(bound_ctl),
    .res_valid(res_valid), .res_data(res_data), .res_we(res_we)
  );

  function automatic string req_of(input int m);
    case (m)
      0: return "R1";
      1: return "R2";
      2, 3: return "R3";
      4, 5: return "R4";
      6: return "R5";
      7: return "R6";
      8, 9, 10, 11: return "R7";
      default: return "R12";
    endcase
  endfunction

  // Source lane per requirement text; -1 = no valid source.
  function automatic int model_src(input int i, input int m, input int n, input logic [7:0] q);
    int base, off;
    base = i - (i % 16);
    off = i % 16;
    case (m)
      0: return i - (i % 4) + ((q >> (2 * (i % 4))) & 3);   // R1
      1: return i - (i % 8) + (7 - (i % 8));                // R2
      2: return (off + n <= 15) ? base + off + n : -1;      // R3 left
      3: return (off - n >= 0) ? base + off - n : -1;       // R3 right
      4: return base + ((off - n + 16) % 16);               // R4 rotate
      5: return base + 15 - off;                            // R4 mirror
      6: return (i >= 16) ? base - 1 : -1;                  // R5
      7: return (i >= 32) ? 31 : -1;                        // R6
      8: return (i == 63) ? -1 : i + 1;                     // R7
      9: return (i == 0) ? -1 : i - 1;
      10: return (i + 1) % 64;
      11: return (i + 63) % 64;
      default: return -1;                                   // R12
    endcase
  endfunction

  task automatic run_case(input int m, input int n, input logic [7:0] q, input logic [3:0] rm,
                          input logic [3:0] bm, input logic bc, input logic [63:0] act,
                          input logic [7:0] salt);
    logic [NL*DW-1:0] exp_d;
    logic [NL-1:0] exp_we;
    @(negedge clk);
    for (int i = 0; i < NL; i++) src_data[i*DW +: DW] = {salt, 2'b00, 6'(i)};
    src_act = act; perm_mode = 4'(m); shift_amt = 4'(n); quad_sel = q;
    row_mask = rm; bank_mask = bm; bound_ctl = bc; issue = 1'b1;
    exp_d = '0; exp_we = '0;
    for (int i = 0; i < NL; i++) begin
      int s;
      bit good, en;
      s = model_src(i, m, n, q);
      good = (s >= 0) && act[s];
      en = rm[i / 16] && bm[(i % 16) / 4];                  // R8
      if (good) exp_d[i*DW +: DW] = {salt, 2'b00, 6'(s)};
      exp_we[i] = en && (good || bc);                       // R9 / R10
    end
    @(negedge clk);
    tests++;
    if (res_valid !== 1'b1 || res_data !== exp_d || res_we !== exp_we) begin
      fails++;
      $display("FAIL %s/R8/R9/R10/R11 mode=%0d n=%0d bc=%0d: valid=%b we=%h data=%h exp we=%h data=%h",
               req_of(m), m, n, bc, res_valid, res_we, res_data, exp_we, exp_d);
    end
  endtask

  task automatic check_idle(input string tag);
    tests++;
    if (res_valid !== 1'b0 || res_we !== '0) begin
      fails++;
      $display("FAIL %s R11 idle: valid=%b we=%h exp valid=0 we=0", tag, res_valid, res_we);
    end
  endtask

  initial begin
    int amts[4] = '{0, 1, 5, 15};
    logic [7:0] qs[4] = '{8'h1B, 8'hE4, 8'h00, 8'h93};
    logic [3:0] rms[4] = '{4'hF, 4'hA, 4'hC, 4'h5};
    logic [3:0] bms[4] = '{4'hF, 4'hF, 4'h6, 4'h9};
    logic [63:0] acts[2] = '{64'hFFFF_FFFF_FFFF_FFFF, 64'h9C3A_5F01_7E96_A5C3};
    repeat (3) @(negedge clk);
    check_idle("reset");                                    // R11 reset state
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("post-reset");
    for (int m = 0; m < 16; m++)
      for (int k = 0; k < 4; k++)
        for (int mk = 0; mk < 4; mk++)
          for (int b = 0; b < 2; b++)
            for (int a = 0; a < 2; a++)
              run_case(m, amts[k], qs[k], rms[mk], bms[mk], 1'(b), acts[a],
                       8'(m * 16 + k * 4 + mk));
    issue = 1'b0;
    @(negedge clk);
    check_idle("after-burst");                              // R11 idle
    @(negedge clk);
    check_idle("steady-idle");
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule